// File: doc/BRIEF.md
# Escaped Word-Stream Frame Extractor

The block takes 32-bit words from a frame queue and turns them back into whole frames. A fixed number of header words comes before each frame. The block counts these words and drops them without looking at their values. After the header, reserved 32-bit codes carried in the word stream mark where a frame ends, how many bytes of the final word are valid, and whether the frame was pruned or aborted. An escape code lets a payload word carry a value equal to one of the reserved codes. A not-ready code is a filler that is skipped.

Payload leaves the block on a valid/ready stream, one 32-bit beat at a time, with a byte keep mask and two flags: last (final beat of the frame) and err (drop this frame). The trailing 4-byte frame check sequence is removed from what is delivered. To do this, the block holds back the two most recent data words until it knows whether they belong to the check sequence. An optional byte swap is applied to each word before it is compared with the reserved codes. Delivered payload words always leave exactly as they arrived. The input is stalled whenever the output beat register is occupied and not being taken.

Top module: `wx_frame_extract`

## Requirements
- R1: The first HDR_WORDS accepted words of every frame are consumed and never decoded or delivered. A reserved code in the header has no effect.
- R2: Every non-reserved word after the header is 4 payload bytes and is delivered unchanged. Lane i is out_data_o[8i+7:8i] and keep bit i belongs to lane i. Every beat that is not the last beat has keep 4'b1111, last=0 and err=0.
- R3: An end code 0x80000000+m (m=0..3) means the last data word held 4-m valid bytes. The last 4 payload bytes are dropped as check sequence. The final beat is the second-to-last data word, with last=1, err=0 and keep set to the low 4-m lanes (m=0: 1111, m=1: 0111, m=2: 0011, m=3: 0001).
- R4: The code 0x80000007 is skipped. It neither ends the frame nor adds data.
- R5: The code 0x80000006 makes the next word payload, even if that word equals a reserved code.
- R6: The code 0x80000004 consumes one more word. The frame then ends with an error beat: data 0, keep 0, last=1, err=1.
- R7: The code 0x80000005 ends the frame at once with an error beat (data 0, keep 0, last=1, err=1).
- R8: An end code that arrives when fewer than two data words have been received ends the frame with an error beat, because no payload remains once the check sequence is removed.
- R9: With swap_en_i=1, each word is byte-reversed before it is compared with the reserved codes. Delivered payload is still the word as received.
- R10: While out_valid_o=1 and out_ready_i=0, in_ready_o=0 and all output fields hold steady. No word is lost or duplicated.
- R11: After reset, out_valid_o=0, in_ready_o=1, and the block expects header words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swap_en_i | input | 1 | Byte-reverse words before code comparison |
| in_data_i | input | 32 | Queue word |
| in_valid_i | input | 1 | Queue word present |
| in_ready_o | output | 1 | Word accepted this cycle when valid |
| out_data_o | output | 32 | Payload beat |
| out_keep_o | output | 4 | Valid byte lanes of the beat |
| out_last_o | output | 1 | Final beat of the frame |
| out_err_o | output | 1 | Frame must be discarded |
| out_valid_o | output | 1 | Beat present |
| out_ready_i | input | 1 | Sink takes the beat |

## Verification
Two things can happen in the same cycle: the beat that ends a frame (or the hold-back shift that emits a data beat) can be produced while the sink is stalling the output. A pseudo-random pattern on out_ready_i and in_valid_i makes end codes, prunes and aborts arrive on stalled and unstalled cycles alike. A cycle-by-cycle check confirms that in_ready_o drops and the stalled beat does not change, and every delivered beat is compared in order against a list computed from the frame lengths. The sweep covers every frame length from 1 to 13 bytes, with each kind of frame ending, and is run with byte swapping both off and on. Some frames have an escaped payload word that collides with a reserved code, and some have filler words inserted.

// File: rtl/wx_pkg.sv
`timescale 1ns/1ps
package wx_pkg;
  localparam int DATA_W     = 32;
  localparam int BYTES      = DATA_W / 8;
  localparam int FCS_BYTES  = 4;
  // words held back so the check sequence can be stripped from the tail
  localparam int HOLD_DEPTH = FCS_BYTES / BYTES + 1;
  localparam int TAIL_W     = $clog2(BYTES + 1);

  typedef enum logic [2:0] {
    WK_DATA, WK_EOF, WK_PRUNE, WK_ABORT, WK_ESC, WK_IDLE
  } word_kind_e;

  typedef enum logic [1:0] {
    ST_HDR, ST_BODY, ST_LIT, ST_DROP
  } ext_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [BYTES-1:0]  keep;
    logic              last;
    logic              err;
  } beat_t;
endpackage

// File: rtl/wx_word_class.sv
`timescale 1ns/1ps
module wx_word_class import wx_pkg::*; (
  input  logic [DATA_W-1:0] word_i,
  input  logic              swap_en_i,
  output word_kind_e        kind_o,
  output logic [TAIL_W-1:0] tail_bytes_o
);
  localparam logic [DATA_W-4:0] CODE_HI = {1'b1, {(DATA_W-4){1'b0}}};

  logic [DATA_W-1:0] rev;
  logic [DATA_W-1:0] cmp;

  for (genvar b = 0; b < BYTES; b++) begin : g_rev
    assign rev[8*b +: 8] = word_i[8*(BYTES-1-b) +: 8];
  end

  assign cmp = swap_en_i ? rev : word_i;

  always_comb begin
    kind_o = WK_DATA;
    if (cmp[DATA_W-1:3] == CODE_HI) begin
      unique case (cmp[2:0])
        3'd4:    kind_o = WK_PRUNE;
        3'd5:    kind_o = WK_ABORT;
        3'd6:    kind_o = WK_ESC;
        3'd7:    kind_o = WK_IDLE;
        default: kind_o = WK_EOF;
      endcase
    end
  end

  // valid bytes of final data word = width minus the low code bits (R3)
  assign tail_bytes_o = TAIL_W'(BYTES) - TAIL_W'(cmp[1:0]);
endmodule

// File: rtl/wx_hold_line.sv
`timescale 1ns/1ps
module wx_hold_line import wx_pkg::*; #(
  parameter int DEPTH = HOLD_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] oldest_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign oldest_o = mem_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk_i) begin
        if (push_i && (full_o || cnt_q == CNT_W'(i))) mem_q[i] <= data_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i) begin
        if (push_i && full_o)                   mem_q[i] <= mem_q[i+1];
        else if (push_i && cnt_q == CNT_W'(i))  mem_q[i] <= data_i;
      end
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_no_push_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && clear_i));
endmodule

// File: rtl/wx_beat_reg.sv
`timescale 1ns/1ps
module wx_beat_reg import wx_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  beat_t beat_i,
  input  logic  out_ready_i,
  output logic  out_valid_o,
  output beat_t beat_o,
  output logic  slot_free_o
);
  logic  valid_q;
  beat_t beat_q;

  assign slot_free_o = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign beat_o      = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          valid_q <= 1'b0;
    else if (load_i)      valid_q <= 1'b1;
    else if (out_ready_i) valid_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= beat_i;
  end

  assert_load_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> slot_free_o);
  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !out_ready_i) |=> (valid_q && $stable(beat_q)));
endmodule

// File: rtl/wx_frame_extract.sv
`timescale 1ns/1ps
module wx_frame_extract import wx_pkg::*; #(
  parameter int HDR_WORDS = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_en_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [BYTES-1:0]  out_keep_o,
  output logic              out_last_o,
  output logic              out_err_o,
  output logic              out_valid_o,
  input  logic              out_ready_i
);
  localparam int          HCNT_W   = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
  localparam logic [HCNT_W-1:0] HDR_LAST = HCNT_W'((HDR_WORDS > 0) ? HDR_WORDS - 1 : 0);
  localparam ext_state_e  ST_FIRST = (HDR_WORDS > 0) ? ST_HDR : ST_BODY;
  localparam logic [BYTES-1:0] KEEP_ALL = '1;

  ext_state_e        st_q, st_d;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  word_kind_e        kind;
  logic [TAIL_W-1:0] tail_bytes;
  logic              slot_free, accept;
  logic              push, clear, load;
  logic              hold_full;
  logic [DATA_W-1:0] hold_old;
  beat_t             beat_d, beat_q;

  wx_word_class u_class (
    .word_i       (in_data_i),
    .swap_en_i    (swap_en_i),
    .kind_o       (kind),
    .tail_bytes_o (tail_bytes)
  );

  wx_hold_line #(.DEPTH(HOLD_DEPTH)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .clear_i  (clear),
    .data_i   (in_data_i),
    .oldest_o (hold_old),
    .full_o   (hold_full)
  );

  wx_beat_reg u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .beat_i      (beat_d),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .beat_o      (beat_q),
    .slot_free_o (slot_free)
  );

  assign in_ready_o = slot_free;
  assign accept     = in_valid_i && slot_free;

  always_comb begin
    st_d   = st_q;
    hcnt_d = hcnt_q;
    push   = 1'b0;
    clear  = 1'b0;
    load   = 1'b0;
    beat_d = '{data: hold_old, keep: KEEP_ALL, last: 1'b0, err: 1'b0};
    if (accept) begin
      unique case (st_q)
        ST_HDR: begin
          if (hcnt_q == HDR_LAST) begin
            hcnt_d = '0;
            st_d   = ST_BODY;
          end else begin
            hcnt_d = hcnt_q + 1'b1;
          end
        end
        ST_LIT: begin
          push = 1'b1;
          load = hold_full;
          st_d = ST_BODY;
        end
        ST_DROP: begin
          load   = 1'b1;
          clear  = 1'b1;
          beat_d = '{data: '0, keep: '0, last: 1'b1, err: 1'b1};
          st_d   = ST_FIRST;
        end
        default: begin
          unique case (kind)
            WK_DATA: begin
              push = 1'b1;
              load = hold_full;
            end
            WK_ESC:   st_d = ST_LIT;
            WK_PRUNE: st_d = ST_DROP;
            WK_ABORT: begin
              load   = 1'b1;
              clear  = 1'b1;
              beat_d = '{data: '0, keep: '0, last: 1'b1, err: 1'b1};
              st_d   = ST_FIRST;
            end
            WK_EOF: begin
              load  = 1'b1;
              clear = 1'b1;
              st_d  = ST_FIRST;
              if (hold_full)
                beat_d = '{data: hold_old, keep: ~(KEEP_ALL << tail_bytes),
                           last: 1'b1, err: 1'b0};
              else
                beat_d = '{data: '0, keep: '0, last: 1'b1, err: 1'b1};
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FIRST;
      hcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      hcnt_q <= hcnt_d;
    end
  end

  assign out_data_o = beat_q.data;
  assign out_keep_o = beat_q.keep;
  assign out_last_o = beat_q.last;
  assign out_err_o  = beat_q.err;

  assert_err_is_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_err_o) |-> out_last_o);
  assert_err_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_err_o) |-> (out_keep_o == '0));
  assert_mid_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> (out_keep_o == KEEP_ALL));
  assert_tail_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o && !out_err_o) |->
      (out_keep_o[0] && ((out_keep_o & (out_keep_o + 1'b1)) == '0)));
  assert_stall_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
  assert_hdr_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HDR) |=> !(out_valid_o && !$past(out_valid_o)));
endmodule

// File: tb/sim_wx_frame_extract.sv
`timescale 1ns/1ps
module sim_wx_frame_extract;
  localparam int HDR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_en = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic        out_last, out_err, out_valid;
  logic        out_ready = 1'b0;

  always #4 clk = ~clk;

  wx_frame_extract #(.HDR_WORDS(HDR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .swap_en_i(swap_en),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_keep_o(out_keep), .out_last_o(out_last),
    .out_err_o(out_err), .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] wl [4096];
  int          wn;
  logic [31:0] e_data [1024];
  logic [3:0]  e_keep [1024];
  logic        e_last [1024];
  logic        e_err  [1024];
  string       e_tag  [1024];
  int          en;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] bsw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] pay_word(input int L, input int j, input bit sw);
    logic [31:0] w;
    bit collide;
    collide = (L >= 9) && (L % 2 == 1);
    for (int b = 0; b < 4; b++) w[8*b +: 8] = 8'(L*17 + 4*j + b + (sw ? 100 : 0));
    if (collide && j == 1) w = sw ? bsw(32'h8000_0000 | 32'(L % 8)) : (32'h8000_0000 | 32'(L % 8));
    return w;
  endfunction

  task automatic put_word(input logic [31:0] w);
    wl[wn] = w;
    wn++;
  endtask

  task automatic exp_beat(input logic [31:0] d, input logic [3:0] k, input logic l,
                          input logic e, input string t);
    e_data[en] = d; e_keep[en] = k; e_last[en] = l; e_err[en] = e; e_tag[en] = t;
    en++;
  endtask

  // endk: 0 end code, 1 prune, 2 abort
  task automatic add_frame(input int L, input int endk, input bit sw);
    int nw, n;
    bit collide, idle;
    logic [31:0] raw, cmpv;
    string pre;
    pre = sw ? "R9/" : "";
    nw = (L + 3) / 4;
    n  = (L % 4 == 0) ? 4 : L % 4;
    collide = (L >= 9) && (L % 2 == 1);
    idle = (L % 3 == 0);
    // R1: header words hold reserved codes that must not act
    for (int h = 0; h < HDR; h++)
      put_word(((h % 2) == 0) ? 32'h8000_0005 : 32'h8000_0001);
    for (int j = 0; j < nw; j++) begin
      raw  = pay_word(L, j, sw);
      cmpv = sw ? bsw(raw) : raw;
      if (cmpv[31:3] == 29'h1000_0000) put_word(sw ? bsw(32'h8000_0006) : 32'h8000_0006);
      put_word(raw);
      if (idle && j == 0) put_word(sw ? bsw(32'h8000_0007) : 32'h8000_0007);
    end
    for (int j = 0; j < nw - 2; j++) begin
      string t;
      t = (collide && j == 1) ? "R5" : ((idle && j == 0) ? "R4" : "R2");
      exp_beat(pay_word(L, j, sw), 4'hF, 1'b0, 1'b0, {pre, t});
    end
    if (endk == 0) begin
      put_word(sw ? bsw(32'h8000_0000 | 32'(4 - n)) : (32'h8000_0000 | 32'(4 - n)));
      if (nw >= 2) exp_beat(pay_word(L, nw - 2, sw), 4'((1 << n) - 1), 1'b1, 1'b0, {pre, "R3"});
      else         exp_beat('0, 4'h0, 1'b1, 1'b1, {pre, "R8"});
    end else if (endk == 1) begin
      put_word(sw ? bsw(32'h8000_0004) : 32'h8000_0004);
      put_word(sw ? bsw(32'h8000_0000) : 32'h8000_0000);
      exp_beat('0, 4'h0, 1'b1, 1'b1, {pre, "R6"});
    end else begin
      put_word(sw ? bsw(32'h8000_0005) : 32'h8000_0005);
      exp_beat('0, 4'h0, 1'b1, 1'b1, {pre, "R7"});
    end
  endtask

  task automatic run_stream(input bit sw);
    int widx, eidx;
    bit stalled;
    logic [31:0] st_data;
    logic [3:0]  st_keep;
    widx = 0; eidx = 0; stalled = 1'b0; st_data = '0; st_keep = '0;
    swap_en = sw;
    while ((widx < wn || eidx < en) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = (widx < wn) && (lfsr[0] | lfsr[3]);
      in_data   = wl[widx];
      out_ready = lfsr[5] | lfsr[7];
      #1;
      if (stalled) begin
        checks++;
        if (out_data !== st_data || out_keep !== st_keep || out_valid !== 1'b1) begin
          fails++;
          $display("FAIL R10 stalled beat changed: got %h/%h exp %h/%h", out_data, out_keep, st_data, st_keep);
        end
      end
      stalled = 1'b0;
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready !== 1'b0) begin
          fails++;
          $display("FAIL R10 in_ready during stall: got %b exp 0", in_ready);
        end
        stalled = 1'b1; st_data = out_data; st_keep = out_keep;
      end
      if (out_valid && out_ready) begin
        checks++;
        if (eidx >= en) begin
          fails++;
          $display("FAIL R1 extra beat: got %h exp none", out_data);
        end else if (out_data !== e_data[eidx] || out_keep !== e_keep[eidx] ||
                     out_last !== e_last[eidx] || out_err !== e_err[eidx]) begin
          fails++;
          $display("FAIL %s beat %0d: got d=%h k=%h l=%b e=%b exp d=%h k=%h l=%b e=%b",
                   e_tag[eidx], eidx, out_data, out_keep, out_last, out_err,
                   e_data[eidx], e_keep[eidx], e_last[eidx], e_err[eidx]);
        end
        eidx++;
      end
      if (in_valid && in_ready) widx++;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      if (out_valid) begin
        eidx++;
        checks++; fails++;
        $display("FAIL R1 trailing beat: got %h exp none", out_data);
      end
    end
    checks++;
    if (cyc >= 150000) begin
      fails++;
      $display("FAIL watchdog: got cycle %0d exp below 150000", cyc);
    end else if (eidx != en || widx != wn) begin
      fails++;
      $display("FAIL R10 stream count: got beats %0d words %0d exp %0d %0d", eidx, widx, en, wn);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R11 out_valid in reset: got %b exp 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R11 after reset: got valid=%b ready=%b exp 0 1", out_valid, in_ready);
    end
    for (int sw = 0; sw < 2; sw++) begin
      wn = 0; en = 0;
      for (int L = 1; L <= 13; L++)
        for (int ek = 0; ek < 3; ek++)
          add_frame(L, ek, sw[0]);
      run_stream(sw[0]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule